// File: doc/BRIEF.md
# Packed SIMD Sum-of-Absolute-Differences Unit

This functional unit sits in one issue slot of a VLIW datapath. Each cycle it may accept one operation made of a 3-bit opcode and two 32-bit source words. One clock later it returns a single 32-bit result, together with a valid strobe. The headline operation treats each source word as four unsigned bytes. It subtracts each pair of bytes that share a position, takes the magnitude of each difference and adds the four magnitudes into one scalar. This is the inner step of block-matching motion search, and it replaces about a dozen scalar instructions with one issue.

Three companion packed operations share the same operand path:
- a per-byte unsigned saturating add,
- a per-halfword signed saturating add,
- a per-byte unsigned average that rounds halves upward.

Any opcode outside the defined set writes zero and raises an illegal-operation flag for that one result. Register file, decode and exception handling live outside the unit.

Top module: `simd_sad_unit`

## Requirements
- R1: While `rst_n` is low, and on the first sampling after it, `out_valid`, `out_illegal` and `out_result` are all zero.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high at the clock edge, and low otherwise. Back-to-back valid inputs give back-to-back results.
- R3: Opcode 0 (SAD) returns the sum over byte positions k = 0..3 of |a[8k+7:8k] − b[8k+7:8k]|. Bytes are paired by position and taken as unsigned. The sum is zero-extended to 32 bits, so the maximum is 1020 (0x3FC).
- R4: Opcode 1 adds the four unsigned byte pairs independently. Any byte whose sum exceeds 255 is clamped to 0xFF.
- R5: Opcode 2 adds the two signed 16-bit halves (bits 31:16 and 15:0) independently. Results above 32767 clamp to 0x7FFF, and results below −32768 clamp to 0x8000.
- R6: Opcode 3 returns, for each unsigned byte pair, (a + b + 1) >> 1 computed without overflow.
- R7: Opcodes 4 to 7 give `out_result` = 0 with `out_illegal` high in the single cycle where `out_valid` is high for that operation. `out_illegal` is never high while `out_valid` is low.
- R8: A cycle with `in_valid` low leaves `out_result` unchanged, whatever the opcode and operands carry.
- R9: No carry, borrow or saturation crosses from one lane into its neighbour in any packed operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 3 | Opcode: 0 SAD, 1 byte sat-add, 2 halfword signed sat-add, 3 byte average |
| in_src_a | input | 32 | First source word |
| in_src_b | input | 32 | Second source word |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_result | output | 32 | Registered result |
| out_illegal | output | 1 | Opcode was not recognised |

## Verification
The bench builds the unit with its default lane width of 8 and lane count of 4. With these values every boundary is a concrete 32-bit pattern:
- the 1020 SAD ceiling,
- the 0xFF byte clamp,
- both 16-bit signed clamps,
- the round-up case of the average.

Vectors are chosen so that one lane saturates or carries while its neighbour does not, which exposes any leak across lanes. Idle cycles with changing operands, illegal opcodes followed by idle cycles, and a reset in mid-run cover the hold and qualification rules.

// File: rtl/simd_sad_pkg.sv
// Shared opcode encoding for the packed SIMD SAD unit.
// Assumes a 3-bit opcode field; codes 4..7 are reserved and treated as illegal.
package simd_sad_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_SAD        = 3'd0,
        OP_ADDSAT_U8  = 3'd1,
        OP_ADDSAT_S16 = 3'd2,
        OP_AVG_U8     = 3'd3
    } simd_op_e;
endpackage

// File: rtl/sad_absdiff_lanes.sv
// Per-lane unsigned absolute difference of two packed words.
// Assumes both words hold NUM_LANES unsigned lanes of LANE_W bits, lane 0 in the low bits.
module sad_absdiff_lanes #(
    parameter  int LANE_W    = 8,
    parameter  int NUM_LANES = 4,
    localparam int DATA_W    = LANE_W * NUM_LANES
) (
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] diffs
);
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_a;
        logic [LANE_W-1:0] lane_b;
        assign lane_a = src_a[g*LANE_W +: LANE_W];
        assign lane_b = src_b[g*LANE_W +: LANE_W];
        // magnitude of the lane difference, subtracting the smaller from the larger
        assign diffs[g*LANE_W +: LANE_W] = (lane_a >= lane_b) ? (lane_a - lane_b)
                                                               : (lane_b - lane_a);
    end
endmodule

// File: rtl/sad_sum_tree.sv
// Balanced binary adder tree that reduces NUM_LANES lane magnitudes to one sum.
// Assumes NUM_LANES is a power of two; the sum width grows by one bit per level so it cannot overflow.
module sad_sum_tree #(
    parameter  int LANE_W    = 8,
    parameter  int NUM_LANES = 4,
    localparam int DATA_W    = LANE_W * NUM_LANES,
    localparam int SUM_W     = LANE_W + $clog2(NUM_LANES),
    localparam int NODES     = 2 * NUM_LANES - 1
) (
    input  logic [DATA_W-1:0] diffs,
    output logic [SUM_W-1:0]  sum
);
    // node 0 is the root; node k has children 2k+1 and 2k+2; leaves start at NUM_LANES-1
    logic [SUM_W-1:0] node [NODES];

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_leaf
        // widen each lane magnitude to the full sum width
        assign node[NUM_LANES-1+g] = SUM_W'(diffs[g*LANE_W +: LANE_W]);
    end

    for (genvar k = 0; k < NUM_LANES - 1; k++) begin : g_inner
        // add the two children of this node
        assign node[k] = node[2*k+1] + node[2*k+2];
    end

    assign sum = node[0];
endmodule

// File: rtl/packed_lane_alu.sv
// Companion packed operations: byte unsigned saturating add, halfword signed
// saturating add and byte unsigned average rounding up.
// Assumes NUM_LANES is even so that pairs of lanes form the wide signed lanes.
module packed_lane_alu #(
    parameter  int LANE_W    = 8,
    parameter  int NUM_LANES = 4,
    localparam int DATA_W    = LANE_W * NUM_LANES,
    localparam int PAIR_W    = 2 * LANE_W,
    localparam int NUM_PAIRS = NUM_LANES / 2
) (
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] addsat_u,
    output logic [DATA_W-1:0] addsat_s,
    output logic [DATA_W-1:0] avg_u
);
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_narrow
        logic [LANE_W:0] wide_sum;
        logic [LANE_W:0] rnd_sum;
        // unsigned lane sum with one spare bit for the carry
        assign wide_sum = {1'b0, src_a[g*LANE_W +: LANE_W]} + {1'b0, src_b[g*LANE_W +: LANE_W]};
        // rounding increment; 2*max+1 still fits in LANE_W+1 bits
        assign rnd_sum  = wide_sum + {{LANE_W{1'b0}}, 1'b1};
        // clamp to all ones when the carry is set
        assign addsat_u[g*LANE_W +: LANE_W] = wide_sum[LANE_W] ? {LANE_W{1'b1}}
                                                               : wide_sum[LANE_W-1:0];
        // halve the rounded sum
        assign avg_u[g*LANE_W +: LANE_W] = rnd_sum[LANE_W:1];
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_wide
        logic [PAIR_W-1:0] op_a;
        logic [PAIR_W-1:0] op_b;
        logic [PAIR_W:0]   s_sum;
        logic              ovf;
        assign op_a  = src_a[p*PAIR_W +: PAIR_W];
        assign op_b  = src_b[p*PAIR_W +: PAIR_W];
        // sign-extended sum, one guard bit wider than the lane
        assign s_sum = {op_a[PAIR_W-1], op_a} + {op_b[PAIR_W-1], op_b};
        // overflow when the guard bit and the lane sign disagree
        assign ovf   = s_sum[PAIR_W] ^ s_sum[PAIR_W-1];
        // pick the extreme of the guard sign on overflow, else the plain sum
        assign addsat_s[p*PAIR_W +: PAIR_W] =
            !ovf           ? s_sum[PAIR_W-1:0] :
            s_sum[PAIR_W]  ? {1'b1, {(PAIR_W-1){1'b0}}} :
                             {1'b0, {(PAIR_W-1){1'b1}}};
    end
endmodule

// File: rtl/simd_sad_unit.sv
// Top of the packed SIMD functional unit. Selects one of four packed results by
// opcode and registers it with its valid and illegal-opcode flags.
// Assumes one operation per cycle at most and a fixed one-cycle latency; the result
// register holds its value on idle cycles.
module simd_sad_unit #(
    parameter  int LANE_W    = 8,
    parameter  int NUM_LANES = 4,
    localparam int DATA_W    = LANE_W * NUM_LANES,
    localparam int SUM_W     = LANE_W + $clog2(NUM_LANES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [simd_sad_pkg::OP_W-1:0] in_op,
    input  logic [DATA_W-1:0]             in_src_a,
    input  logic [DATA_W-1:0]             in_src_b,
    output logic                          out_valid,
    output logic [DATA_W-1:0]             out_result,
    output logic                          out_illegal
);
    import simd_sad_pkg::*;

    logic [DATA_W-1:0] lane_diffs;
    logic [SUM_W-1:0]  sad_sum;
    logic [DATA_W-1:0] res_addsat_u;
    logic [DATA_W-1:0] res_addsat_s;
    logic [DATA_W-1:0] res_avg_u;
    logic [DATA_W-1:0] next_result;
    logic              op_legal;

    sad_absdiff_lanes #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_absdiff (
        .src_a (in_src_a),
        .src_b (in_src_b),
        .diffs (lane_diffs)
    );

    sad_sum_tree #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_tree (
        .diffs (lane_diffs),
        .sum   (sad_sum)
    );

    packed_lane_alu #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_alu (
        .src_a    (in_src_a),
        .src_b    (in_src_b),
        .addsat_u (res_addsat_u),
        .addsat_s (res_addsat_s),
        .avg_u    (res_avg_u)
    );

    // opcode decode: choose the result and flag unknown codes
    always_comb begin
        op_legal    = 1'b1;
        next_result = '0;
        case (in_op)
            OP_SAD:        next_result = DATA_W'(sad_sum);
            OP_ADDSAT_U8:  next_result = res_addsat_u;
            OP_ADDSAT_S16: next_result = res_addsat_s;
            OP_AVG_U8:     next_result = res_avg_u;
            default:       op_legal    = 1'b0;
        endcase
    end

    // output stage: one-cycle latency, result held while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            out_result  <= '0;
        end else begin
            out_valid   <= in_valid;
            out_illegal <= in_valid & ~op_legal;
            if (in_valid) begin
                out_result <= next_result;
            end
        end
    end
endmodule

// File: rtl/simd_sad_unit_chk.sv
// Protocol checker for simd_sad_unit, attached to every instance by bind.
// Assumes the default lane layout when checking the SAD ceiling.
module simd_sad_unit_chk #(
    parameter  int LANE_W    = 8,
    parameter  int NUM_LANES = 4,
    localparam int DATA_W    = LANE_W * NUM_LANES,
    localparam int SAD_MAX   = ((1 << LANE_W) - 1) * NUM_LANES
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_valid,
    input logic [simd_sad_pkg::OP_W-1:0] in_op,
    input logic [DATA_W-1:0]             out_result,
    input logic                          out_valid,
    input logic                          out_illegal
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_SAD_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd0) |=> (out_result <= DATA_W'(SAD_MAX))); // R3
    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_result == '0)); // R7
    AST_ILLEGAL_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> out_valid); // R7
    AST_ILLEGAL_FROM_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[2]) |=> out_illegal); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result)); // R8
endmodule

bind simd_sad_unit simd_sad_unit_chk #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) chk_i (.*);

// File: tb/simd_sad_unit_tb_top.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module simd_sad_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic [31:0] in_src_a = '0;
    logic [31:0] in_src_b = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_illegal;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    simd_sad_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_src_a(in_src_a), .in_src_b(in_src_b),
        .out_valid(out_valid), .out_result(out_result), .out_illegal(out_illegal)
    );

    // {op, a, b, expected result, expected illegal}
    localparam int NV = 13;
    localparam logic [99:0] VEC [NV] = '{
        {3'd0, 32'h0A14_1E28, 32'h0514_2832, 32'h0000_0019, 1'b0}, // R3 mixed
        {3'd0, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_03FC, 1'b0}, // R3 ceiling
        {3'd0, 32'h0000_0000, 32'hFF00_FF00, 32'h0000_01FE, 1'b0}, // R3 b larger
        {3'd0, 32'h1234_5678, 32'h1234_5678, 32'h0000_0000, 1'b0}, // R3 equal
        {3'd1, 32'h807F_01FF, 32'h8001_FE01, 32'hFF80_FFFF, 1'b0}, // R4 R9 clamp beside no clamp
        {3'd1, 32'h0102_0304, 32'h1020_3040, 32'h1122_3344, 1'b0}, // R4 plain
        {3'd2, 32'h7FFF_0001, 32'h0001_0002, 32'h7FFF_0003, 1'b0}, // R5 positive clamp
        {3'd2, 32'h8000_FFFF, 32'hFFFF_FFFF, 32'h8000_FFFE, 1'b0}, // R5 negative clamp
        {3'd2, 32'h1234_FF00, 32'h0001_0100, 32'h1235_0000, 1'b0}, // R5 R9 low wrap, no carry up
        {3'd3, 32'hFF00_0103, 32'hFF00_0204, 32'hFF00_0204, 1'b0}, // R6 round up
        {3'd3, 32'h00FF_1080, 32'h0100_207F, 32'h0180_1880, 1'b0}, // R6 R9
        {3'd4, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1}, // R7
        {3'd7, 32'h0A0A_0A0A, 32'h0101_0101, 32'h0000_0000, 1'b1}  // R7
    };

    function automatic string tag_for(logic [2:0] op);
        case (op)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic issue(logic [2:0] op, logic [31:0] a, logic [31:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_src_a = a; in_src_b = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state while held in reset
        check("R1", "valid", 32'(out_valid), 32'd0);
        check("R1", "result", out_result, 32'd0);
        check("R1", "illegal", 32'(out_illegal), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "valid after release", 32'(out_valid), 32'd0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][99:97], VEC[i][96:65], VEC[i][64:33]);
            check(tag_for(VEC[i][99:97]), $sformatf("vec%0d result", i), out_result, VEC[i][32:1]);
            check("R2", $sformatf("vec%0d valid", i), 32'(out_valid), 32'd1);
            check("R7", $sformatf("vec%0d illegal", i), 32'(out_illegal), 32'(VEC[i][0]));
        end

        // R7: illegal flag lasts one cycle
        @(negedge clk);
        check("R7", "illegal drops", 32'(out_illegal), 32'd0);
        check("R2", "valid drops", 32'(out_valid), 32'd0);

        // R8: idle cycles with changing inputs leave the result alone
        issue(3'd0, 32'h0102_0304, 32'h0403_0201); // SAD = 3+1+1+3 = 8
        held = out_result;
        check("R3", "small sad", held, 32'd8);
        for (int k = 0; k < 3; k++) begin
            in_op = 3'(k + 1); in_src_a = 32'hDEAD_BEEF; in_src_b = 32'h1234_0000 + 32'(k);
            @(negedge clk);
            check("R8", "idle hold result", out_result, held);
            check("R8", "idle valid low", 32'(out_valid), 32'd0);
            check("R7", "idle illegal low", 32'(out_illegal), 32'd0);
        end

        // R2: back-to-back operations each give a result next cycle
        @(negedge clk);
        in_valid = 1'b1; in_op = 3'd1; in_src_a = 32'hF0F0_F0F0; in_src_b = 32'h2020_0101;
        @(negedge clk);
        check("R4", "b2b first", out_result, 32'hFFFF_F1F1);
        check("R2", "b2b first valid", 32'(out_valid), 32'd1);
        in_op = 3'd3; in_src_a = 32'h0000_00FF; in_src_b = 32'h0000_00FE;
        @(negedge clk);
        check("R6", "b2b second", out_result, 32'h0000_00FF);
        check("R2", "b2b second valid", 32'(out_valid), 32'd1);
        in_valid = 1'b0;

        // R1: reset in mid-run clears outputs
        issue(3'd0, 32'hFFFF_FFFF, 32'h0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "mid reset result", out_result, 32'd0);
        check("R1", "mid reset valid", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule